// File: doc/BRIEF.md
# Fixed-Schedule Sequential Integer Divider

This unit computes the quotient and remainder of two 32-bit integers, treated either as signed or as unsigned values, next to an integer pipeline. A one-cycle start pulse presents the operands. The divider then follows a fixed, labelled schedule and presents its results a set number of cycles later. The schedule runs as follows:

- cycle 1: turn the operands into magnitudes;
- cycle 2: set up the partial remainder;
- cycles 3 to 34: one non-restoring add/subtract iteration per quotient bit;
- cycle 35: correct a negative partial remainder;
- cycle 36: give the quotient and the remainder their final signs;
- cycle 37: write the results.

The latency does not depend on the data, so the surrounding pipeline can plan the write-back slot from the cycle of the start pulse. The busy output covers the whole operation, and done marks the write cycle. A divisor of zero runs the same schedule and raises no error.

Top module: `seqdiv_unit`

## Requirements
- R1: After reset, busy_o and done_o are 0, and quotient_o and remainder_o are 0.
- R2: A start_i sampled high while busy_o is 0 is accepted, and busy_o is 1 from the next cycle up to and including the done cycle. busy_o returns to 0 in the cycle after done.
- R3: done_o is high in exactly the 37th cycle after the accepting clock edge. That edge counts as the first.
- R4: With is_signed_i = 0, quotient_o is the floor of dividend/divisor and remainder_o is dividend minus quotient times divisor, with 0 <= remainder < divisor.
- R5: With is_signed_i = 1, the quotient is truncated toward zero. It is negative only when exactly one operand is negative, and the remainder carries the sign of the dividend.
- R6: The signed case 0x80000000 / 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R7: A start_i that arrives while busy_o is 1 is ignored. This includes the done cycle. Such a pulse changes neither the result nor the timing of the running operation, and it does not start a new one.
- R8: A zero divisor still takes the full 37 cycles and flags nothing. The remainder equals the dividend. The quotient is 0xFFFFFFFF, or 0x00000001 when is_signed_i = 1 and the dividend is negative.
- R9: done_o is a one-cycle pulse. quotient_o and remainder_o keep their values until the next accepted operation writes new ones.
- R10: At the end of every iteration phase, after 32 iterations, the corrected partial remainder is non-negative and smaller than a non-zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| is_signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend_i | input | 32 | Dividend, captured on the accepted start |
| divisor_i | input | 32 | Divisor, captured on the accepted start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Results written this cycle |
| quotient_o | output | 32 | Quotient result register |
| remainder_o | output | 32 | Remainder result register |

## Verification
The assertions check the protocol on every cycle:

- done always lies inside busy and lasts one cycle;
- an idle start leads to the sign-adjust step;
- a busy period holds until done;
- the remainder adjust follows exactly the last iteration;
- the corrected remainder lies in range.

The arithmetic itself, the exact 37-cycle latency, the zero-divisor results and the fact that late start pulses are ignored can be shown only by the bench's scenarios. They compare the ports against a reference model built on wide integer arithmetic.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SADJ  = 3'd1,
        PH_EARLY = 3'd2,
        PH_ITER  = 3'd3,
        PH_RADJ  = 3'd4,
        PH_SFIX  = 3'd5,
        PH_WRITE = 3'd6
    } div_phase_e;

endpackage

// File: rtl/seqdiv_operand_prep.sv
module seqdiv_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    input  logic         is_signed_i,
    output logic [W-1:0] num_mag_o,
    output logic [W-1:0] den_mag_o,
    output logic         quo_neg_o,
    output logic         rem_neg_o
);
    logic num_neg, den_neg;

    always_comb begin
        num_neg   = is_signed_i & num_i[W-1];
        den_neg   = is_signed_i & den_i[W-1];
        num_mag_o = num_neg ? (~num_i + 1'b1) : num_i;
        den_mag_o = den_neg ? (~den_i + 1'b1) : den_i;
        quo_neg_o = num_neg ^ den_neg;
        rem_neg_o = num_neg;
    end
endmodule

// File: rtl/seqdiv_nr_step.sv
module seqdiv_nr_step #(
    parameter int W  = 32,
    localparam int RW = W + 2
) (
    input  logic [RW-1:0] rem_i,
    input  logic          bit_in_i,
    input  logic [W-1:0]  den_i,
    output logic [RW-1:0] rem_o,
    output logic          qbit_o
);
    logic [RW-1:0] shifted, den_ext;

    always_comb begin
        shifted = {rem_i[RW-2:0], bit_in_i};
        den_ext = {2'b00, den_i};
        rem_o   = rem_i[RW-1] ? (shifted + den_ext) : (shifted - den_ext);
        qbit_o  = ~rem_o[RW-1];
    end
endmodule

// File: rtl/seqdiv_result_fix.sv
module seqdiv_result_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag_i,
    input  logic [W-1:0] rem_mag_i,
    input  logic         quo_neg_i,
    input  logic         rem_neg_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    always_comb begin
        quo_o = quo_neg_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
        rem_o = rem_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
    end
endmodule

// File: rtl/seqdiv_unit.sv
module seqdiv_unit #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         is_signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o
);
    import seqdiv_pkg::*;

    localparam int CW = $clog2(W);
    localparam int RW = W + 2;
    localparam logic [CW-1:0] LAST_ITER = CW'(W - 1);

    typedef struct packed {
        div_phase_e    ph;
        logic [CW-1:0] cnt;
        logic [W-1:0]  opa;
        logic [W-1:0]  opb;
        logic          sgn;
        logic          quo_neg;
        logic          rem_neg;
        logic [W-1:0]  dvs;
        logic [W-1:0]  quo;
        logic [RW-1:0] rem;
        logic [W-1:0]  res_q;
        logic [W-1:0]  res_r;
    } div_regs_t;

    div_regs_t st_d, st_q;

    logic [W-1:0]  mag_a, mag_b;
    logic          flag_qn, flag_rn;
    logic [RW-1:0] step_rem;
    logic          step_bit;
    logic [W-1:0]  fix_q, fix_r;

    seqdiv_operand_prep #(.W(W)) i_prep (
        .num_i       (st_q.opa),
        .den_i       (st_q.opb),
        .is_signed_i (st_q.sgn),
        .num_mag_o   (mag_a),
        .den_mag_o   (mag_b),
        .quo_neg_o   (flag_qn),
        .rem_neg_o   (flag_rn)
    );

    seqdiv_nr_step #(.W(W)) i_step (
        .rem_i    (st_q.rem),
        .bit_in_i (st_q.quo[W-1]),
        .den_i    (st_q.dvs),
        .rem_o    (step_rem),
        .qbit_o   (step_bit)
    );

    seqdiv_result_fix #(.W(W)) i_fix (
        .quo_mag_i (st_q.quo),
        .rem_mag_i (st_q.rem[W-1:0]),
        .quo_neg_i (st_q.quo_neg),
        .rem_neg_i (st_q.rem_neg),
        .quo_o     (fix_q),
        .rem_o     (fix_r)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.opa = dividend_i;
                    st_d.opb = divisor_i;
                    st_d.sgn = is_signed_i;
                    st_d.ph  = PH_SADJ;
                end
            end
            PH_SADJ: begin
                st_d.quo     = mag_a;
                st_d.dvs     = mag_b;
                st_d.quo_neg = flag_qn;
                st_d.rem_neg = flag_rn;
                st_d.ph      = PH_EARLY;
            end
            PH_EARLY: begin
                st_d.rem = '0;
                st_d.cnt = '0;
                st_d.ph  = PH_ITER;
            end
            PH_ITER: begin
                st_d.rem = step_rem;
                st_d.quo = {st_q.quo[W-2:0], step_bit};
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST_ITER) begin
                    st_d.ph = PH_RADJ;
                end
            end
            PH_RADJ: begin
                if (st_q.rem[RW-1]) begin
                    st_d.rem = st_q.rem + {2'b00, st_q.dvs};
                end
                st_d.ph = PH_SFIX;
            end
            PH_SFIX: begin
                st_d.res_q = fix_q;
                st_d.res_r = fix_r;
                st_d.ph    = PH_WRITE;
            end
            PH_WRITE: begin
                st_d.ph = PH_IDLE;
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = (st_q.ph != PH_IDLE);
    assign done_o      = (st_q.ph == PH_WRITE);
    assign quotient_o  = st_q.res_q;
    assign remainder_o = st_q.res_r;

    assert_done_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> busy_o);

    assert_start_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> (busy_o && st_q.ph == PH_SADJ));

    assert_busy_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> busy_o);

    assert_iter_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_RADJ) |-> ($past(st_q.ph) == PH_ITER && $past(st_q.cnt) == LAST_ITER));

    assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_results_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph != PH_SFIX) |=> ($stable(quotient_o) && $stable(remainder_o)));

    assert_rem_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ph == PH_SFIX) |-> (!st_q.rem[RW-1] &&
                                  (st_q.dvs == '0 || st_q.rem[W-1:0] < st_q.dvs)));
endmodule

// File: tb/test_seqdiv_unit.sv
module test_seqdiv_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 37;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic        is_signed_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        busy_o, done_o;
    logic [31:0] quotient_o, remainder_o;

    int n_checks = 0;
    int n_fail   = 0;

    seqdiv_unit i_seqdiv_unit (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .is_signed_i (is_signed_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void ref_div(input logic [31:0] a, input logic [31:0] b,
                                    input logic s, output logic [31:0] q,
                                    output logic [31:0] r);
        longint sa, sb;
        if (b == 0) begin
            r = a;
            q = (s && a[31]) ? 32'h1 : 32'hFFFF_FFFF;
        end else if (s) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            q  = 32'(sa / sb);
            r  = 32'(sa % sb);
        end else begin
            q = a / b;
            r = a % b;
        end
    endfunction

    // One operation; inject_at > 0 drives a foreign start at that cycle,
    // poke_done drives a foreign start during the done cycle.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                          input int inject_at, input bit poke_done, input string req);
        int cyc;
        logic [31:0] eq, er;
        ref_div(a, b, s, eq, er);
        @(negedge clk_i);
        start_i = 1'b1; is_signed_i = s; dividend_i = a; divisor_i = b;
        @(posedge clk_i);
        cyc = 1;
        @(negedge clk_i);
        start_i = 1'b0;
        check("R2", "busy after accept", 32'(busy_o), 32'h1);
        while (!done_o && cyc < 100) begin
            if (inject_at > 0 && cyc == inject_at) begin
                start_i = 1'b1; is_signed_i = ~s;
                dividend_i = ~a; divisor_i = b ^ 32'h5;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk_i);
            cyc++;
            @(negedge clk_i);
        end
        start_i = 1'b0;
        check("R3", "latency", 32'(cyc), 32'(LATENCY));
        check(req, "quotient", quotient_o, eq);
        check(req, "remainder", remainder_o, er);
        if (poke_done) begin
            start_i = 1'b1; dividend_i = 32'h1234; divisor_i = 32'h7;
        end
        @(posedge clk_i);
        @(negedge clk_i);
        start_i = 1'b0;
        check("R9", "done pulse ends", 32'(done_o), 32'h0);
        check(poke_done ? "R7" : "R2", "idle after done", 32'(busy_o), 32'h0);
        check("R9", "quotient held", quotient_o, eq);
        check("R9", "remainder held", remainder_o, er);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb;
        int seed_dummy;
        seed_dummy = $urandom(32'd20417);
        #(CLK_PERIOD * 3);
        @(negedge clk_i);
        check("R1", "busy at reset", 32'(busy_o), 32'h0);
        check("R1", "done at reset", 32'(done_o), 32'h0);
        check("R1", "quotient at reset", quotient_o, 32'h0);
        check("R1", "remainder at reset", remainder_o, 32'h0);
        rst_ni = 1'b1;

        // directed corners
        run_op(32'd100, 32'd7, 1'b0, 0, 1'b0, "R4");
        run_op(32'hFFFF_FFFF, 32'd1, 1'b0, 0, 1'b0, "R4");
        run_op(32'd5, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, "R4");
        run_op(32'hFFFF_FFF9, 32'd2, 1'b1, 0, 1'b0, "R5");
        run_op(32'd7, 32'hFFFF_FFFE, 1'b1, 0, 1'b0, "R5");
        run_op(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1, 0, 1'b0, "R5");
        run_op(32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b0, 0, 1'b0, "R10");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0, 1'b0, "R6");
        run_op(32'd1234, 32'd0, 1'b0, 0, 1'b0, "R8");
        run_op(32'hFFFF_FF00, 32'd0, 1'b1, 0, 1'b0, "R8");
        run_op(32'h0000_0100, 32'd0, 1'b1, 0, 1'b0, "R8");
        run_op(32'd999, 32'd10, 1'b0, 5, 1'b0, "R7");
        run_op(32'hF000_0001, 32'd3, 1'b1, 30, 1'b1, "R7");

        // constrained random
        for (int i = 0; i < 300; i++) begin
            ra = $urandom;
            case ($urandom % 4)
                0: rb = $urandom % 16;
                1: rb = $urandom % 65536;
                2: rb = -($urandom % 8);
                default: rb = $urandom;
            endcase
            run_op(ra, rb, 1'($urandom % 2), ((i % 17) == 0) ? 10 : 0,
                   ((i % 13) == 0), "R4/R5 random");
        end

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule